// File: doc/BRIEF.md
# Programmable-Rate TDM Serial Input Deserializer

This block turns a set of frame-aligned serial TDM input lines into channel bytes for a time-slot switch. All lines share one master bit clock and one frame pulse. Each line runs at its own bit rate. A rate is modelled as a clock-enable division of the master clock, and the frame is always 125 us long. A slow line carries few channels per frame and a fast line carries many. The master clock ticks once per bit of the fastest rate, which is 32.768 Mbps, so one frame is 4096 master ticks.

Each line also has a channel offset and a fine bit offset. These move the point where channel 0 starts, so data that arrives late against the common frame pulse is still labelled with the right channel. A wide mode runs the lower half of the lines at the top rate and ignores the upper half. Completed bytes from all lines go to the switch data memory through one write port. Each write carries a stream number, a channel number and a byte. A round-robin arbiter with one holding slot per line feeds this port.

Top module: `tdm_ingress_deser`

## Requirements
- R1: While reset is held, and for the first cycles after it is released, `wr_valid` is 0.
- R2: In normal mode a line's rate code 0, 1, 2 or 3 selects a bit period of 16, 8, 4 or 2 master cycles. The line then has 32, 64, 128 or 256 channels per frame, and each channel is written exactly once per frame.
- R3: Bits are received MSB first. A byte is offered for writing once its eighth bit is captured, and it carries the channel number it belongs to.
- R4: The master cycle in which `frame_pulse` is high is tick 0 of the frame. With zero offsets, channel 0 bit 7 occupies the first bit period from tick 0, and each bit is sampled in the last master cycle of its bit period.
- R5: A channel offset of k moves the start of channel 0 later by 8·k bit periods.
- R6: A channel offset at or above the line's channel count behaves as that offset modulo the channel count.
- R7: A bit offset of d moves the sampling of the whole line later by d master cycles.
- R8: When `wide_mode` is 1, lines 0 to 7 run with a bit period of 1 master cycle and 512 channels per frame, whatever their rate codes.
- R9: When `wide_mode` is 1, lines 8 to 15 produce no writes, whatever data they carry.
- R10: Under full load no byte is lost. This covers every line at the top normal rate, or the wide mode with all offsets equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master bit clock (one tick per 32.768 Mbps bit) |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_pulse | input | 1 | High for one master cycle at tick 0 of each frame |
| wide_mode | input | 1 | 1: lines 0-7 at top rate, lines 8-15 ignored |
| rx_line | input | 16 | Serial input lines, bit i is line i |
| cfg_rate | input | 32 | Rate code per line, 2 bits each, line i at [2i+1:2i] |
| cfg_ch_dly | input | 144 | Channel offset per line, 9 bits each, line i at [9i+8:9i] |
| cfg_bit_dly | input | 80 | Bit offset in master cycles, 5 bits each, line i at [5i+4:5i] |
| wr_valid | output | 1 | Write strobe toward the data memory |
| wr_stream | output | 4 | Line number of the byte being written |
| wr_chan | output | 9 | Channel number of the byte being written |
| wr_data | output | 8 | Received byte |

## Verification
Every line carries a byte pattern that depends on both its line number and its channel number. A byte written under the wrong channel number, or shifted by a bit, therefore shows up as a data miscompare. A missed byte or a doubled byte shows up in the per-line count of writes over two steady frames. A mix of rate codes with zero offsets separates the four bit-period divisions and the start-of-frame alignment. Staggered channel and bit offsets at full normal load test the offset arithmetic and whether the arbiter can keep up. Offsets above the channel count test the wrap. Wide mode with odd rate codes, and with busy upper lines, tells the forced top rate apart from the programmed one and shows that the ignored half writes nothing.

// File: rtl/tdm_rx_pkg.sv
// Shared definitions for the TDM input deserializer.
// Assumes the master clock ticks once per bit of the fastest rate.
package tdm_rx_pkg;

    // Log2 of the highest division ratio (rate code 0 = /16).
    localparam int unsigned MAX_DIV_LOG2 = 4;

    typedef enum logic [1:0] {
        RATE_DIV16 = 2'd0,
        RATE_DIV8  = 2'd1,
        RATE_DIV4  = 2'd2,
        RATE_DIV2  = 2'd3
    } rate_code_t;

    // Log2 of a line's bit period in master cycles.
    function automatic logic [2:0] period_log2(input logic [1:0] code,
                                               input logic       top_rate);
        if (top_rate) begin
            return 3'd0;
        end
        return 3'(MAX_DIV_LOG2) - {1'b0, code};
    endfunction

endpackage

// File: rtl/tdm_frame_timer.sv
// Frame tick counter. The cycle in which frame_pulse is high is tick 0.
// Between pulses the counter runs freely and wraps at 2**TICK_W, which
// equals one frame. A missing pulse therefore leaves the timing intact.
module tdm_frame_timer #(
    parameter int unsigned TICK_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_pulse,
    output logic [TICK_W-1:0] tick
);

    logic [TICK_W-1:0] next_q;

    // Current tick: forced to zero by the frame pulse.
    assign tick = frame_pulse ? '0 : next_q;

    // Advance the prediction of the next tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_q <= '0;
        end else begin
            next_q <= tick + TICK_W'(1);
        end
    end

    // R4: after a frame pulse the next cycle is tick 1 unless a new pulse arrives
    a_r4_frame_origin: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pulse |=> (frame_pulse || tick == TICK_W'(1)));

endmodule

// File: rtl/tdm_lane_rx.sv
// One serial line receiver. It places the line's bit grid on the frame
// as pos = tick - offset (mod frame), where offset = channel_offset *
// 8 * period + bit_offset. It samples in the last master cycle of each
// bit period and shifts the bits in MSB first. On the eighth bit it
// offers a byte and its channel number.
// Assumes: 2**TICK_W master cycles per frame, so that 8 * period *
// channel_count equals the frame. The modulo-frame truncation of the
// offset then also wraps the channel offset modulo the channel count.
module tdm_lane_rx
    import tdm_rx_pkg::*;
#(
    parameter int unsigned IDX        = 0,
    parameter int unsigned FAST_LANES = 8,
    parameter int unsigned TICK_W     = 12,
    parameter int unsigned CHD_W      = 9,
    parameter int unsigned BD_W       = 5,
    parameter int unsigned CH_W       = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TICK_W-1:0] tick,
    input  logic              wide_mode,
    input  logic [1:0]        rate,
    input  logic [CHD_W-1:0]  ch_dly,
    input  logic [BD_W-1:0]   bit_dly,
    input  logic              din,
    output logic              done,
    output logic [7:0]        byte_o,
    output logic [CH_W-1:0]   chan_o
);

    localparam bit IS_FAST = (IDX < FAST_LANES);

    logic              lane_on;
    logic              top_rate;
    logic [2:0]        plog;
    logic [TICK_W-1:0] offset;
    logic [TICK_W-1:0] pos;
    logic [TICK_W-1:0] sub_mask;
    logic              sample;
    logic [2:0]        bit_no;
    logic [6:0]        shreg;
    logic [3:0]        gap;

    // Mode decode: wide mode speeds up the lower lines and mutes the upper ones.
    always_comb begin
        top_rate = wide_mode && IS_FAST;
        lane_on  = !wide_mode || IS_FAST;
        plog     = period_log2(rate, top_rate);
    end

    // Bit-grid placement within the frame.
    always_comb begin
        offset   = TICK_W'(32'(ch_dly) << ({29'd0, plog} + 32'd3))
                 + TICK_W'(bit_dly);
        pos      = tick - offset;
        sub_mask = TICK_W'((32'd1 << plog) - 32'd1);
        sample   = ((pos & sub_mask) == sub_mask);
        bit_no   = 3'(pos >> plog);
        chan_o   = CH_W'(pos >> ({29'd0, plog} + 32'd3));
    end

    // Byte completion on the eighth sampled bit.
    always_comb begin
        done   = lane_on && sample && (bit_no == 3'd7);
        byte_o = {shreg, din};
    end

    // Shift register holding the seven bits already received.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (sample) begin
            shreg <= {shreg[5:0], din};
        end
    end

    // Checker state: cycles since the last completed byte (8 = none yet).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap <= 4'd8;
        end else if (done) begin
            gap <= 4'd0;
        end else if (gap != 4'd8) begin
            gap <= gap + 4'd1;
        end
    end

    // R3: bytes of one line are at least eight master cycles apart
    a_r3_byte_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (gap >= 4'd7));

endmodule

// File: rtl/tdm_wr_arbiter.sv
// Collects completed bytes from all lines into one holding slot per line
// and drains them round-robin onto a single registered write port.
// Assumes NS is a power of two and that the total byte rate is at most one
// per cycle, with each line's byte interval no shorter than the number of
// lines that can be active.
module tdm_wr_arbiter #(
    parameter int unsigned NS   = 16,
    parameter int unsigned CH_W = 9,
    localparam int unsigned SW  = $clog2(NS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NS-1:0]   post,
    input  logic [7:0]      byte_in [NS],
    input  logic [CH_W-1:0] chan_in [NS],
    output logic            wr_valid,
    output logic [SW-1:0]   wr_stream,
    output logic [CH_W-1:0] wr_chan,
    output logic [7:0]      wr_data
);

    logic [NS-1:0]   pend;
    logic [7:0]      hold_byte [NS];
    logic [CH_W-1:0] hold_chan [NS];
    logic [SW-1:0]   ptr;
    logic [SW-1:0]   sel;
    logic            found;
    logic [NS-1:0]   gnt;

    // Round-robin pick of the first pending slot at or after the pointer.
    always_comb begin
        found = 1'b0;
        sel   = '0;
        gnt   = '0;
        for (int k = 0; k < NS; k++) begin
            logic [SW-1:0] idx;
            idx = ptr + SW'(k);
            if (!found && pend[idx]) begin
                found    = 1'b1;
                sel      = idx;
                gnt[idx] = 1'b1;
            end
        end
    end

    // Holding slots: a new byte takes priority over the drain of the old one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
            for (int i = 0; i < NS; i++) begin
                hold_byte[i] <= '0;
                hold_chan[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NS; i++) begin
                if (post[i]) begin
                    pend[i]      <= 1'b1;
                    hold_byte[i] <= byte_in[i];
                    hold_chan[i] <= chan_in[i];
                end else if (gnt[i]) begin
                    pend[i] <= 1'b0;
                end
            end
        end
    end

    // Registered write port and pointer advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid  <= 1'b0;
            wr_stream <= '0;
            wr_chan   <= '0;
            wr_data   <= '0;
            ptr       <= '0;
        end else begin
            wr_valid <= found;
            if (found) begin
                wr_stream <= sel;
                wr_chan   <= hold_chan[sel];
                wr_data   <= hold_byte[sel];
                ptr       <= sel + SW'(1);
            end
        end
    end

    // R10: at most one slot is drained per cycle
    a_r10_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    for (genvar g = 0; g < NS; g++) begin : g_ovf
        // R10: a pending byte is drained no later than the cycle its successor arrives
        a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
            (pend[g] && post[g]) |-> gnt[g]);
    end

endmodule

// File: rtl/tdm_ingress_deser.sv
// Top of the TDM input deserializer: a frame timer, one receiver per
// serial line, and a round-robin write port toward the switch data memory.
// Assumes frame_pulse is synchronous to clk and that the configuration
// changes only while reset is held.
module tdm_ingress_deser #(
    parameter int unsigned NS      = 16,
    parameter int unsigned MAX_CH  = 512,
    parameter int unsigned CHD_W   = 9,
    parameter int unsigned BD_W    = 5,
    localparam int unsigned TICK_W = $clog2(MAX_CH * 8),
    localparam int unsigned CH_W   = $clog2(MAX_CH),
    localparam int unsigned SW     = $clog2(NS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_pulse,
    input  logic               wide_mode,
    input  logic [NS-1:0]      rx_line,
    input  logic [NS*2-1:0]    cfg_rate,
    input  logic [NS*CHD_W-1:0] cfg_ch_dly,
    input  logic [NS*BD_W-1:0] cfg_bit_dly,
    output logic               wr_valid,
    output logic [SW-1:0]      wr_stream,
    output logic [CH_W-1:0]    wr_chan,
    output logic [7:0]         wr_data
);

    logic [TICK_W-1:0] tick;
    logic [NS-1:0]     lane_done;
    logic [7:0]        lane_byte [NS];
    logic [CH_W-1:0]   lane_chan [NS];

    tdm_frame_timer #(.TICK_W(TICK_W)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_pulse (frame_pulse),
        .tick        (tick)
    );

    for (genvar s = 0; s < NS; s++) begin : g_lane
        tdm_lane_rx #(
            .IDX        (s),
            .FAST_LANES (NS / 2),
            .TICK_W     (TICK_W),
            .CHD_W      (CHD_W),
            .BD_W       (BD_W),
            .CH_W       (CH_W)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .wide_mode (wide_mode),
            .rate      (cfg_rate[s*2 +: 2]),
            .ch_dly    (cfg_ch_dly[s*CHD_W +: CHD_W]),
            .bit_dly   (cfg_bit_dly[s*BD_W +: BD_W]),
            .din       (rx_line[s]),
            .done      (lane_done[s]),
            .byte_o    (lane_byte[s]),
            .chan_o    (lane_chan[s])
        );
    end

    tdm_wr_arbiter #(.NS(NS), .CH_W(CH_W)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .post      (lane_done),
        .byte_in   (lane_byte),
        .chan_in   (lane_chan),
        .wr_valid  (wr_valid),
        .wr_stream (wr_stream),
        .wr_chan   (wr_chan),
        .wr_data   (wr_data)
    );

    // R1: the write port is idle in the first cycle out of reset
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !wr_valid);

endmodule

// File: tb/tb_tdm_ingress_deser.sv
// Directed bench: each scenario resets the block with a configuration,
// drives every line from a channel-labelled pattern and scores the writes
// taken over two steady frames.
module tb_tdm_ingress_deser;

    localparam int NS    = 16;
    localparam int FT    = 4096;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            frame_pulse = 1'b0;
    logic            wide_mode = 1'b0;
    logic [NS-1:0]   rx_line = '0;
    logic [NS*2-1:0] cfg_rate = '0;
    logic [NS*9-1:0] cfg_ch_dly = '0;
    logic [NS*5-1:0] cfg_bit_dly = '0;
    logic            wr_valid;
    logic [3:0]      wr_stream;
    logic [8:0]      wr_chan;
    logic [7:0]      wr_data;

    int n_checks = 0;
    int n_fails  = 0;
    int rate_c [NS];
    int cd_c   [NS];
    int bd_c   [NS];
    bit wide_c;
    int cnt    [NS];
    int mism   [NS];

    always #5 clk = ~clk;

    tdm_ingress_deser dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_pulse (frame_pulse),
        .wide_mode   (wide_mode),
        .rx_line     (rx_line),
        .cfg_rate    (cfg_rate),
        .cfg_ch_dly  (cfg_ch_dly),
        .cfg_bit_dly (cfg_bit_dly),
        .wr_valid    (wr_valid),
        .wr_stream   (wr_stream),
        .wr_chan     (wr_chan),
        .wr_data     (wr_data)
    );

    function automatic logic [7:0] pat(int s, int ch);
        return 8'(s * 29 + ch * 7 + (ch >> 5) * 3 + 8'h5A);
    endfunction

    function automatic int period(int s);
        if (wide_c && s < 8) return 1;
        return 16 >> rate_c[s];
    endfunction

    // Line level at tick t, placed from R4/R5/R6/R7 with the offset reduced here.
    function automatic logic line_bit(int s, int t);
        int div, nch, off, pos, b;
        logic [7:0] v;
        if (wide_c && s >= 8) return logic'((t * 5 + s) % 3 == 0);
        div = period(s);
        nch = FT / (8 * div);
        off = ((cd_c[s] % nch) * 8 * div + bd_c[s]) % FT;
        pos = (t - off + FT) % FT;
        b   = pos / div;
        v   = pat(s, (b / 8) % nch);
        return v[7 - (b % 8)];
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic load_cfg();
        wide_mode = wide_c;
        for (int s = 0; s < NS; s++) begin
            cfg_rate[s*2 +: 2]   = 2'(rate_c[s]);
            cfg_ch_dly[s*9 +: 9] = 9'(cd_c[s]);
            cfg_bit_dly[s*5 +: 5] = 5'(bd_c[s]);
        end
    endtask

    // Reset, run three frames, score writes seen in frames 1 and 2.
    task automatic run_scenario(string req);
        @(negedge clk);
        rst_n = 1'b0;
        frame_pulse = 1'b0;
        load_cfg();
        for (int s = 0; s < NS; s++) begin
            cnt[s] = 0;
            mism[s] = 0;
        end
        repeat (3) @(negedge clk);
        for (int n = 0; n <= 3 * FT + 1; n++) begin
            if (n > 0) @(negedge clk);
            if (n >= FT + 1 && n < 3 * FT + 1 && wr_valid) begin
                cnt[wr_stream]++;
                if (wr_data != pat(int'(wr_stream), int'(wr_chan))) mism[wr_stream]++;
            end
            rst_n = 1'b1;
            frame_pulse = ((n % FT) == 0);
            for (int s = 0; s < NS; s++) rx_line[s] = line_bit(s, n % FT);
        end
        for (int s = 0; s < NS; s++) begin
            int exp;
            exp = (wide_c && s >= 8) ? 0 : 2 * (FT / (8 * period(s)));
            check(cnt[s] == exp, req, $sformatf("stream %0d write count", s), cnt[s], exp);
            if (exp > 0)
                check(mism[s] == 0, req, $sformatf("stream %0d data miscompares", s), mism[s], 0);
        end
    endtask

    // R1: idle write port during and just after reset.
    task automatic t_reset();
        wide_c = 1'b0;
        for (int s = 0; s < NS; s++) begin
            rate_c[s] = 0; cd_c[s] = 0; bd_c[s] = 0;
        end
        load_cfg();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(wr_valid == 1'b0, "R1", "wr_valid in reset", int'(wr_valid), 0);
        rst_n = 1'b1;
        frame_pulse = 1'b1;
        @(negedge clk);
        frame_pulse = 1'b0;
        repeat (8) @(negedge clk);
        check(wr_valid == 1'b0, "R1", "wr_valid after release", int'(wr_valid), 0);
    endtask

    // R2 R3 R4: mixed rate codes, zero offsets.
    task automatic t_mixed_rates();
        wide_c = 1'b0;
        for (int s = 0; s < NS; s++) begin
            rate_c[s] = s % 4; cd_c[s] = 0; bd_c[s] = 0;
        end
        run_scenario("R2/R3/R4");
    endtask

    // R5 R7 R10: every line at rate code 3, staggered offsets.
    task automatic t_offsets_full_load();
        wide_c = 1'b0;
        for (int s = 0; s < NS; s++) begin
            rate_c[s] = 3; cd_c[s] = s * 13 % 256; bd_c[s] = (s * 7) % 32;
        end
        run_scenario("R5/R7/R10");
    endtask

    // R6: channel offsets beyond the channel count wrap.
    task automatic t_offset_wrap();
        wide_c = 1'b0;
        for (int s = 0; s < NS; s++) begin
            rate_c[s] = (s + 1) % 4;
            cd_c[s]   = (32 << rate_c[s]) + s * 3;
            if (cd_c[s] > 511) cd_c[s] = 511;
            bd_c[s]   = 31 - s;
        end
        run_scenario("R6");
    endtask

    // R8 R9 R10: wide mode, equal offsets, odd rate codes on the fast lines.
    task automatic t_wide_aligned();
        wide_c = 1'b1;
        for (int s = 0; s < NS; s++) begin
            rate_c[s] = s % 4; cd_c[s] = 0; bd_c[s] = 0;
        end
        run_scenario("R8/R9/R10");
    endtask

    // R8 R9 R5 R7: wide mode with large channel and bit offsets.
    task automatic t_wide_offsets();
        wide_c = 1'b1;
        for (int s = 0; s < NS; s++) begin
            rate_c[s] = 3 - (s % 4); cd_c[s] = 500 + s; bd_c[s] = 31 - s;
        end
        run_scenario("R8/R9/R5/R7");
    endtask

    initial begin
        t_reset();
        t_mixed_rates();
        t_offsets_full_load();
        t_offset_wrap();
        t_wide_aligned();
        t_wide_offsets();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule